// File: doc/BRIEF.md
# Programmable Clock Frequency Generator

This block is a bank of programmable clock dividers. Each generator picks one of three fast source clocks, divides it by a ratio set in a shared control word, and drives a divided clock output. The source clocks come from phase-locked loops outside the block. Here they are presented as single-cycle tick strobes on the block's own clock, so one tick marks one source period. Each generator output is a registered level that changes only on the block clock.

Software writes the whole control word through a simple write port and can read it back unchanged. The word interpretation has two variants, picked by a mode input. The legacy variant has a one-bit source choice, a separate enable bit and even ratios only. The extended variant has a two-bit source code in which zero means off, and a global scale bit that permits any integer ratio. A new setting is applied only at the boundary between two output periods, so a reprogrammed or stopped output never produces a truncated pulse.

Top module: `freq_gen`

## Requirements
- R1: While reset is asserted and right after it, the control word reads zero and every generator output is low.
- R2: Reading the control word returns exactly the last value written, including bits that no generator decodes (bits 30 and 31 included).
- R3: Generator g is controlled by the 10-bit slice starting at bit 10*g. Within the slice, bits 9..2 hold the divider code N, and writing one slice leaves the other generators disabled and low.
- R4: With the mode input low (legacy), slice bit 0 selects the source (0 = CPU tick, 1 = auxiliary tick), slice bit 1 enables the generator, and the ratio is (N+1)*2 whatever the value of bit 30.
- R5: With the mode input high (extended), slice bits 1..0 are a source code: 0 = off, 1 = second auxiliary tick, 2 = CPU tick, 3 = auxiliary tick.
- R6: In extended mode, bit 30 of the word set gives a ratio of N+1 (1 to 256), and bit 30 clear gives (N+1)*2 (2 to 512).
- R7: For a ratio R of at least 2, each output period spans R ticks of the selected source. The output is high for floor(R/2) of them and low for the rest. A rise only follows a selected source tick.
- R8: With a ratio of 1, the output is high for exactly the one block cycle that follows each selected source tick.
- R9: A new source or ratio written while a generator runs takes effect only after the current output period has completed in full.
- R10: A stop request completes the current period, then holds the output low. After re-enabling, the first period has its full length.
- R11: Ticks of sources that are not selected have no effect on a generator's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all source ticks are sampled on it |
| rstN | input | 1 | Asynchronous active-low reset |
| extMode | input | 1 | 0 = legacy word layout, 1 = extended layout |
| cpuTick | input | 1 | One pulse per CPU source clock period |
| auxTick | input | 1 | One pulse per auxiliary source clock period |
| aux2Tick | input | 1 | One pulse per second auxiliary source clock period |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | REG_W | Control word value to write |
| rdData | output | REG_W | Current control word |
| genClk | output | NUM_GEN | Divided clock, one bit per generator |

## Verification
The delicate overlap is a register write that arrives while a generator sits inside an output period. The last source tick of that period must then both close the old period and load the new setting, in the same cycle. The bench provokes this by writing a new ratio, or a stop, on the cycle right after a rising edge of a running output. It judges the result by counting the high and low lengths of the interrupted period, which must match the old ratio, and then the length of the next period. A companion test stops and restarts the generator in the same way and measures the first restarted period against the full ratio.

// File: rtl/freq_gen_pkg.sv
package freq_gen_pkg;

  localparam int NUM_SRC = 3;

  // Internal source index; the tick vector is packed in this order.
  typedef enum logic [1:0] {
    SRC_AUX2 = 2'd0,
    SRC_CPU  = 2'd1,
    SRC_AUX  = 2'd2
  } srcSel_e;

  // Strobes from the control half to the counter half.
  typedef struct packed {
    logic tick;   // selected source advanced this cycle
    logic clear;  // generator idle: zero the counter, drive low
  } dpStrobe_t;

endpackage

// File: rtl/freq_gen_ctrl.sv
module freq_gen_ctrl
  import freq_gen_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                extMode,
  input  logic                scaleBit,
  input  logic [DIV_W+1:0]    field,
  input  logic [NUM_SRC-1:0]  srcTicks,
  input  logic                wrapNow,
  output dpStrobe_t           strobe,
  output logic [DIV_W+1:0]    ratio,
  output logic                active
);

  localparam int RATIO_W = DIV_W + 2;

  logic [DIV_W-1:0]   divCode;
  logic [RATIO_W-1:0] unitRatio;
  logic [RATIO_W-1:0] evenRatio;

  logic               liveOn;
  srcSel_e            liveSrc;
  logic [RATIO_W-1:0] liveRatio;

  logic               activeOn;
  srcSel_e            activeSrc;
  logic [RATIO_W-1:0] activeRatio;
  logic               adopt;

  assign divCode   = field[RATIO_W-1:2];
  assign unitRatio = RATIO_W'(divCode) + RATIO_W'(1);
  assign evenRatio = unitRatio << 1;

  // Decode of the live slice in the variant picked by the mode input.
  always_comb begin
    liveOn    = 1'b0;
    liveSrc   = SRC_CPU;
    liveRatio = evenRatio;
    if (extMode) begin
      liveOn = (field[1:0] != 2'd0);
      unique case (field[1:0])
        2'd1:    liveSrc = SRC_AUX2;
        2'd2:    liveSrc = SRC_CPU;
        2'd3:    liveSrc = SRC_AUX;
        default: liveSrc = SRC_CPU;
      endcase
      liveRatio = scaleBit ? unitRatio : evenRatio;
    end else begin
      liveOn    = field[1];
      liveSrc   = field[0] ? SRC_AUX : SRC_CPU;
      liveRatio = evenRatio;
    end
  end

  // Settings move into the active copy only between output periods,
  // or at once while the generator is idle.
  assign adopt = !activeOn || wrapNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeOn    <= 1'b0;
      activeSrc   <= SRC_CPU;
      activeRatio <= RATIO_W'(2);
    end else if (adopt) begin
      activeOn    <= liveOn;
      activeSrc   <= liveSrc;
      activeRatio <= liveRatio;
    end
  end

  always_comb begin
    strobe.tick  = activeOn && srcTicks[activeSrc];
    strobe.clear = !activeOn;
  end

  assign ratio  = activeRatio;
  assign active = activeOn;

endmodule

// File: rtl/freq_gen_dp.sv
module freq_gen_dp
  import freq_gen_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [DIV_W+1:0] ratio,
  output logic             clkOut,
  output logic             wrapNow
);

  localparam int RATIO_W = DIV_W + 2;
  localparam int CNT_W   = RATIO_W - 1;

  logic [CNT_W-1:0]   phaseCnt;
  logic [RATIO_W-1:0] hiLen;
  logic               isUnit;
  logic               lastSlot;

  assign hiLen    = ratio >> 1;
  assign isUnit   = (ratio == RATIO_W'(1));
  assign lastSlot = ({1'b0, phaseCnt} == (ratio - RATIO_W'(1)));
  assign wrapNow  = strobe.tick && lastSlot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      clkOut   <= 1'b0;
    end else if (strobe.clear) begin
      phaseCnt <= '0;
      clkOut   <= 1'b0;
    end else if (isUnit) begin
      phaseCnt <= '0;
      clkOut   <= strobe.tick;
    end else if (strobe.tick) begin
      clkOut   <= ({1'b0, phaseCnt} < hiLen);
      phaseCnt <= lastSlot ? '0 : phaseCnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/freq_gen.sv
module freq_gen
  import freq_gen_pkg::*;
#(
  parameter int NUM_GEN   = 3,
  parameter int DIV_W     = 8,
  parameter int REG_W     = 32,
  parameter int SCALE_POS = 30
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               extMode,
  input  logic               cpuTick,
  input  logic               auxTick,
  input  logic               aux2Tick,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  output logic [NUM_GEN-1:0] genClk
);

  localparam int FIELD_W = DIV_W + 2;

  logic [REG_W-1:0]   ctrlReg;
  logic [NUM_SRC-1:0] srcTicks;
  logic [NUM_GEN-1:0] genActive;

  assign srcTicks = {auxTick, cpuTick, aux2Tick};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     ctrlReg <= '0;
    else if (wrEn) ctrlReg <= wrData;
  end

  assign rdData = ctrlReg;

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    dpStrobe_t          strobe;
    logic [FIELD_W-1:0] ratio;
    logic               wrapNow;

    freq_gen_ctrl #(.DIV_W(DIV_W)) u_ctrl (
      .clk      (clk),
      .rstN     (rstN),
      .extMode  (extMode),
      .scaleBit (ctrlReg[SCALE_POS]),
      .field    (ctrlReg[g*FIELD_W +: FIELD_W]),
      .srcTicks (srcTicks),
      .wrapNow  (wrapNow),
      .strobe   (strobe),
      .ratio    (ratio),
      .active   (genActive[g])
    );

    freq_gen_dp #(.DIV_W(DIV_W)) u_dp (
      .clk     (clk),
      .rstN    (rstN),
      .strobe  (strobe),
      .ratio   (ratio),
      .clkOut  (genClk[g]),
      .wrapNow (wrapNow)
    );
  end

endmodule

// File: rtl/freq_gen_checker.sv
module freq_gen_checker #(
  parameter int NUM_GEN = 3,
  parameter int REG_W   = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               cpuTick,
  input logic               auxTick,
  input logic               aux2Tick,
  input logic               wrEn,
  input logic [REG_W-1:0]   wrData,
  input logic [REG_W-1:0]   rdData,
  input logic [NUM_GEN-1:0] genClk,
  input logic [NUM_GEN-1:0] genActive
);

  logic anyTick;
  assign anyTick = cpuTick || auxTick || aux2Tick;

  // R1: reset clears word and outputs
  always @(negedge clk) begin
    if (!rstN) begin
      a_r1_reset_clear: assert (rdData == '0 && genClk == '0)
        else $error("reset state not clear");
    end
  end

  // R2: the word reads back as written
  a_r2_readback: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rdData == $past(wrData)));

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
    // R10: an idle generator drives low on the next cycle
    a_r10_idle_low: assert property (@(posedge clk) disable iff (!rstN)
      !genActive[g] |=> !genClk[g]);

    // R7: no rise without a source tick
    a_r7_rise_needs_tick: assert property (@(posedge clk) disable iff (!rstN)
      (!anyTick && !genClk[g]) |=> !genClk[g]);
  end

endmodule

bind freq_gen freq_gen_checker #(.NUM_GEN(NUM_GEN), .REG_W(REG_W)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .cpuTick   (cpuTick),
  .auxTick   (auxTick),
  .aux2Tick  (aux2Tick),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .rdData    (rdData),
  .genClk    (genClk),
  .genActive (genActive)
);

// File: tb/freq_gen_bench.sv
module freq_gen_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        extMode = 1'b0;
  logic        cpuTick = 1'b0;
  logic        auxTick = 1'b0;
  logic        aux2Tick = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [2:0]  genClk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  bit cpuRun = 1, auxRun = 1, aux2Run = 1;
  int cyc = 0;

  freq_gen u_freq_gen (
    .clk(clk), .rstN(rstN), .extMode(extMode), .cpuTick(cpuTick),
    .auxTick(auxTick), .aux2Tick(aux2Tick), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .genClk(genClk)
  );

  always #2 clk = ~clk;  // 250 MHz

  // Source ticks: CPU every cycle, aux every 2nd, aux2 every 3rd.
  always @(posedge clk) begin
    #1;
    cyc++;
    cpuTick  = cpuRun;
    auxTick  = auxRun && (cyc % 2 == 0);
    aux2Tick = aux2Run && (cyc % 3 == 0);
  end

  // Source code used by the bench: 0 CPU, 1 aux, 2 aux2.
  typedef struct packed {
    logic       ext;
    logic [31:0] word;
    logic [1:0] gen;
    logic [1:0] src;
    logic [9:0] per;
    logic [9:0] hi;
  } vec_t;

  localparam vec_t VECS [0:8] = '{
    '{1'b0, 32'h0000000A, 2'd0, 2'd0, 10'd6,   10'd3},
    '{1'b0, 32'h00001C00, 2'd1, 2'd1, 10'd4,   10'd2},
    '{1'b0, 32'h40300000, 2'd2, 2'd1, 10'd2,   10'd1},
    '{1'b1, 32'h00000011, 2'd0, 2'd2, 10'd10,  10'd5},
    '{1'b1, 32'h40004800, 2'd1, 2'd0, 10'd5,   10'd2},
    '{1'b1, 32'h41B00000, 2'd2, 2'd1, 10'd7,   10'd3},
    '{1'b1, 32'h4000001E, 2'd0, 2'd0, 10'd8,   10'd4},
    '{1'b0, 32'h000003FE, 2'd0, 2'd0, 10'd512, 10'd256},
    '{1'b1, 32'h400FF800, 2'd1, 2'd0, 10'd256, 10'd128}
  };

  function automatic logic tickOf(input logic [1:0] s);
    case (s)
      2'd0:    return cpuTick;
      2'd1:    return auxTick;
      default: return aux2Tick;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [31:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  // Ticks of the chosen source per output period, and how many fell high.
  task automatic measure(input int g, input logic [1:0] s,
                         output int per, output int hi);
    bit lastClk, prevTick, started, done;
    int cnt, hiC;
    per = -1; hi = -1; started = 0; done = 0; cnt = 0; hiC = 0;
    @(negedge clk);
    lastClk = genClk[g]; prevTick = tickOf(s);
    for (int n = 0; n < 4000 && !done; n++) begin
      bit cur;
      @(negedge clk);
      cur = genClk[g];
      if (cur && !lastClk) begin
        if (started) begin
          per = cnt; hi = hiC; done = 1;
        end
        started = 1; cnt = 0; hiC = 0;
      end
      if (!done && started && prevTick) begin
        cnt++;
        if (cur) hiC++;
      end
      lastClk = cur; prevTick = tickOf(s);
    end
  endtask

  task automatic countHigh(input int g, input int n, output int h);
    h = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (genClk[g]) h++;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    int per, hi, h, t, hiLen, loLen;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(rdData == 0, "R1", "word after reset", rdData, 0);
    check(genClk == 0, "R1", "outputs after reset", genClk, 0);

    // Vector table
    for (int i = 0; i < 9; i++) begin
      vec_t v;
      v = VECS[i];
      writeReg(32'h0);
      repeat (600) @(negedge clk);
      extMode = v.ext;
      writeReg(v.word);
      measure(v.gen, v.src, per, hi);
      check(per == v.per, v.ext ? "R3 R5 R6 R7" : "R3 R4 R7",
            $sformatf("vector %0d period", i), per, v.per);
      check(hi == v.hi, v.ext ? "R3 R5 R6 R7" : "R3 R4 R7",
            $sformatf("vector %0d high ticks", i), hi, v.hi);
      check((genClk & ~(3'b1 << v.gen)) == 0, "R3",
            $sformatf("vector %0d other generators", i),
            genClk & ~(3'b1 << v.gen), 0);
    end
    writeReg(32'h0);
    repeat (600) @(negedge clk);

    // R2: readback including undecoded bits (gen0 legacy, disabled)
    extMode = 1'b0;
    writeReg(32'hC0000001);
    @(negedge clk);
    check(rdData == 32'hC0000001, "R2", "readback", rdData, 32'hC0000001);
    countHigh(0, 60, h);
    check(h == 0, "R4", "legacy enable bit clear", h, 0);
    writeReg(32'h0);

    // R5: extended code 0 means off
    extMode = 1'b1;
    writeReg(32'h4000000C);
    countHigh(0, 60, h);
    check(h == 0, "R5", "extended source code 0", h, 0);
    writeReg(32'h0);

    // R8: ratio 1 on the aux source
    writeReg(32'h40000003);
    repeat (10) @(negedge clk);
    begin
      bit prevT;
      int bad;
      h = 0; t = 0; bad = 0;
      prevT = auxTick;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (prevT) t++;
        if (genClk[0]) h++;
        if (genClk[0] != prevT) bad++;
        prevT = auxTick;
      end
      check(h == t && t == 20, "R8", "unit ratio pulses", h, t);
      check(bad == 0, "R8", "unit ratio pulse placement", bad, 0);
    end
    writeReg(32'h0);
    repeat (20) @(negedge clk);

    // R11: CPU selected, CPU ticks stopped, others running
    extMode = 1'b0;
    cpuRun = 0;
    writeReg(32'h00000002);
    countHigh(0, 60, h);
    check(h == 0, "R11", "unselected ticks ignored", h, 0);
    cpuRun = 1;
    measure(0, 2'd0, per, hi);
    check(per == 2 && hi == 1, "R11", "resumed period", per, 2);
    writeReg(32'h0);
    repeat (20) @(negedge clk);

    // R9: ratio change written just after a rise
    extMode = 1'b1;
    writeReg(32'h40000026);
    measure(0, 2'd0, per, hi);
    while (!(genClk[0])) @(negedge clk);
    while (genClk[0]) @(negedge clk);
    while (!(genClk[0])) @(negedge clk);
    wrEn = 1'b1; wrData = 32'h40000006;
    hiLen = 0;
    do begin
      hiLen++;
      @(negedge clk);
      wrEn = 1'b0;
    end while (genClk[0]);
    loLen = 0;
    while (!genClk[0] && loLen < 100) begin
      loLen++;
      @(negedge clk);
    end
    check(hiLen == 5, "R9", "high of interrupted period", hiLen, 5);
    check(loLen == 5, "R9", "low of interrupted period", loLen, 5);
    measure(0, 2'd0, per, hi);
    check(per == 2 && hi == 1, "R9", "period after change", per, 2);

    // R10: stop written just after a rise, then restart
    writeReg(32'h40000026);
    repeat (30) @(negedge clk);
    while (genClk[0]) @(negedge clk);
    while (!(genClk[0])) @(negedge clk);
    wrEn = 1'b1; wrData = 32'h40000000;
    hiLen = 0;
    do begin
      hiLen++;
      @(negedge clk);
      wrEn = 1'b0;
    end while (genClk[0]);
    check(hiLen == 5, "R10", "high before stop", hiLen, 5);
    countHigh(0, 50, h);
    check(h == 0, "R10", "held low after stop", h, 0);
    writeReg(32'h40000026);
    measure(0, 2'd0, per, hi);
    check(per == 10, "R10", "first period after restart", per, 10);
    check(hi == 5, "R10", "first high after restart", hi, 5);

    finished = 1;
    summary();
    $finish;
  end

endmodule